// File: doc/BRIEF.md
# Address-space-tagged translation buffer with shared entries

This block is a small, fully associative cache of page translations. Each slot holds a valid bit, a virtual page number, a physical page number, a shared (global) flag and an address-space tag. A lookup presents a virtual page number. The block compares it against every slot in parallel, together with the address-space tag on the `cur_asid` input, and returns hit/miss and the physical page in the same cycle.

A fill writes one translation. If the translation is not shared, it is tagged with the value on `cur_asid`, so the tag never travels with the request. Two flush commands exist. One empties the whole buffer. The other removes only the per-process slots and keeps the shared ones, which cover the common kernel mappings. Because slots are tagged, two processes can map the same virtual page at the same time, and a context switch needs no flush.

A refill of a translation that is already visible overwrites that slot in place. A new translation goes to the lowest-numbered empty slot. When no slot is empty, a rotating pointer picks the slot to replace.

Top module: `asid_tlb`

## Requirements
- R1: After reset every slot is empty: any lookup reports `lk_hit`=0 and `lk_ppn`=0.
- R2: A lookup hits when a valid slot has the same virtual page number and either its shared flag is set or its tag equals `cur_asid`. Hit and physical page appear combinationally in the same cycle. On a miss `lk_ppn` is 0.
- R3: A fill with `fill_global`=0 stores the slot tagged with `cur_asid` from that cycle. The translation is visible to lookups from the cycle after the clock edge.
- R4: Two slots with the same virtual page number and different tags coexist. Each lookup returns only the page that belongs to its own tag, and all ASID_W bits of the tag are compared (the default is 16, and the design also works with 8).
- R5: `flush_all` empties every slot at the next clock edge.
- R6: `flush_local` empties every slot whose shared flag is 0 at the next clock edge. Shared slots keep their contents and stay visible.
- R7: A fill whose virtual page number would already hit under `cur_asid` overwrites that slot. No second slot is consumed.
- R8: A fill that hits nothing goes to the lowest-numbered empty slot. If the buffer is full, it replaces the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping at ENTRIES, for each such full-buffer replacement.
- R9: A flush command takes priority over a fill in the same cycle, and the fill is dropped. `flush_all` takes priority over `flush_local`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | ASID_W | Tag of the current address space, used by lookups and fills |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hit slot, 0 on a miss |
| fill_en | input | 1 | Write a translation at the next edge |
| fill_vpn | input | VPN_W | Virtual page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_global | input | 1 | Marks the filled slot as shared by all address spaces |
| flush_all | input | 1 | Empty every slot |
| flush_local | input | 1 | Empty the per-process slots only |

## Verification
The directed patterns cover several cases in turn:
- Same page, two tags: two tags that differ only in their top bit map the same virtual page, which separates a full-width tag compare from a truncated one.
- Shared entry: a shared translation is looked up under unrelated tags and must survive a local flush.
- Replacement order: a full buffer is refilled repeatedly, which separates an in-place overwrite from a fresh allocation and shows the rotation order of replacements.
- Command collisions: a fill coincides with a flush.

The random phase mixes fills, both flushes and lookups over a small page pool, under four tags, against a model of the slot table. It exposes slip-ups in victim choice after partial flushes.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE,
    OP_FILL,
    OP_FLUSH_ALL,
    OP_FLUSH_LOCAL
  } tlb_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 16
) (
  input  logic [ENTRIES-1:0]             valid,
  input  logic [ENTRIES-1:0]             glob,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid,
  input  logic [VPN_W-1:0]               key_vpn,
  input  logic [ASID_W-1:0]              key_asid,
  output logic [ENTRIES-1:0]             hit
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit[g] = valid[g] && (vpn[g] == key_vpn) &&
                    (glob[g] || (asid[g] == key_asid));
  end
endmodule

// File: rtl/tlb_prio.sv
module tlb_prio #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [ENTRIES-1:0] req,
  output logic               any,
  output logic [IW-1:0]      idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full,
  input  logic          alloc,
  input  logic [IW-1:0] free_idx,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] rr_q, rr_d;
  logic          rr_en;

  assign rr_en = alloc && full;

  always_comb begin
    rr_d = rr_q;
    if (rr_en) begin
      rr_d = (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  assign victim = full ? rr_q : free_idx;

  // R8: a full-buffer allocation moves the rotating pointer
  assert_rr_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && full) |=> (rr_q != $past(rr_q)));
  // R8: no allocation leaves the pointer where it is
  assert_rr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc && full) |=> $stable(rr_q));
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASID_W  = 16,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_global,
  input  logic              flush_all,
  input  logic              flush_local
);
  logic [ENTRIES-1:0]             e_valid_q, e_valid_d;
  logic [ENTRIES-1:0]             e_glob_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] e_asid_q;
  logic [ENTRIES-1:0]             wr_en;

  tlb_op_e op;
  always_comb begin
    if (flush_all)        op = OP_FLUSH_ALL;
    else if (flush_local) op = OP_FLUSH_LOCAL;
    else if (fill_en)     op = OP_FILL;
    else                  op = OP_IDLE;
  end

  // lookup path
  logic [ENTRIES-1:0] lk_match;
  logic [IW-1:0]      lk_idx;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_lk_match (
    .valid(e_valid_q), .glob(e_glob_q), .vpn(e_vpn_q), .asid(e_asid_q),
    .key_vpn(lk_vpn), .key_asid(cur_asid), .hit(lk_match)
  );
  tlb_prio #(.ENTRIES(ENTRIES)) i_lk_prio (
    .req(lk_match), .any(lk_hit), .idx(lk_idx)
  );
  assign lk_ppn = lk_hit ? e_ppn_q[lk_idx] : '0;

  // fill path
  logic [ENTRIES-1:0] fl_match;
  logic               fl_hit;
  logic [IW-1:0]      fl_idx;
  logic               free_any;
  logic [IW-1:0]      free_idx;
  logic [IW-1:0]      victim;
  logic [IW-1:0]      tgt;
  logic               alloc;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_fl_match (
    .valid(e_valid_q), .glob(e_glob_q), .vpn(e_vpn_q), .asid(e_asid_q),
    .key_vpn(fill_vpn), .key_asid(cur_asid), .hit(fl_match)
  );
  tlb_prio #(.ENTRIES(ENTRIES)) i_fl_prio (
    .req(fl_match), .any(fl_hit), .idx(fl_idx)
  );
  tlb_prio #(.ENTRIES(ENTRIES)) i_free_prio (
    .req(~e_valid_q), .any(free_any), .idx(free_idx)
  );

  assign alloc = (op == OP_FILL) && !fl_hit;

  tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
    .clk(clk), .rst_n(rst_n), .full(!free_any), .alloc(alloc),
    .free_idx(free_idx), .victim(victim)
  );

  assign tgt = fl_hit ? fl_idx : victim;

  // next state
  always_comb begin
    e_valid_d = e_valid_q;
    wr_en     = '0;
    unique case (op)
      OP_FLUSH_ALL:   e_valid_d = '0;
      OP_FLUSH_LOCAL: e_valid_d = e_valid_q & e_glob_q;
      OP_FILL: begin
        wr_en[tgt]     = 1'b1;
        e_valid_d[tgt] = 1'b1;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_valid_q <= '0;
    else        e_valid_q <= e_valid_d;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        e_vpn_q[g]  <= fill_vpn;
        e_ppn_q[g]  <= fill_ppn;
        e_glob_q[g] <= fill_global;
        e_asid_q[g] <= fill_global ? '0 : cur_asid;
      end
    end
  end

  // assertions
  assert_fill_occupies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_FILL) |=> (e_valid_q != '0));
  assert_flush_all_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (e_valid_q == '0));
  assert_flush_local_private_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !flush_all) |=> ((e_valid_q & ~e_glob_q) == '0));
  assert_flush_local_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_local && !flush_all) |=> ((e_valid_q & e_glob_q) == $past(e_valid_q & e_glob_q)));
  assert_refill_in_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == OP_FILL) && fl_hit) |=> ($countones(e_valid_q) == $past($countones(e_valid_q))));
  assert_fill_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && flush_all) |=> !lk_hit || $past(1'b0));
  assert_miss_no_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0));
endmodule

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 20;
  localparam int PPN_W   = 20;
  localparam int ASID_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ASID_W-1:0] cur_asid;
  logic [VPN_W-1:0]  lk_vpn;
  logic              lk_hit;
  logic [PPN_W-1:0]  lk_ppn;
  logic              fill_en;
  logic [VPN_W-1:0]  fill_vpn;
  logic [PPN_W-1:0]  fill_ppn;
  logic              fill_global;
  logic              flush_all;
  logic              flush_local;

  always #4 clk = ~clk;

  asid_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W)) i_asid_tlb (
    .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_global(fill_global), .flush_all(flush_all),
    .flush_local(flush_local)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference slot table
  logic             m_v    [ENTRIES];
  logic             m_g    [ENTRIES];
  logic [VPN_W-1:0] m_vpn  [ENTRIES];
  logic [PPN_W-1:0] m_ppn  [ENTRIES];
  logic [ASID_W-1:0] m_asid[ENTRIES];
  int               m_rr;

  function automatic logic [PPN_W:0] model_look(input logic [VPN_W-1:0] v,
                                                input logic [ASID_W-1:0] a);
    logic [PPN_W:0] r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) r = {1'b1, m_ppn[i]};
    return r;
  endfunction

  function automatic int model_hit_idx(input logic [VPN_W-1:0] v,
                                       input logic [ASID_W-1:0] a);
    int r = -1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == v && (m_g[i] || m_asid[i] == a)) r = i;
    return r;
  endfunction

  task automatic model_apply(input bit f, input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                             input bit g, input logic [ASID_W-1:0] a, input bit fa, input bit fl);
    int t;
    if (fa) begin
      for (int i = 0; i < ENTRIES; i++) m_v[i] = 1'b0;
    end else if (fl) begin
      for (int i = 0; i < ENTRIES; i++) if (!m_g[i]) m_v[i] = 1'b0;
    end else if (f) begin
      t = model_hit_idx(v, a);
      if (t < 0) begin
        for (int i = ENTRIES - 1; i >= 0; i--) if (!m_v[i]) t = i;
        if (t < 0) begin
          t = m_rr;
          m_rr = (m_rr + 1) % ENTRIES;
        end
      end
      m_v[t] = 1'b1; m_g[t] = g; m_vpn[t] = v; m_ppn[t] = p; m_asid[t] = a;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // lookup at negedge phase, compares against literal expectation
  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic hit, input logic [PPN_W-1:0] p, input string req);
    lk_vpn = v; cur_asid = a;
    #1;
    check(req, {43'd0, lk_hit, lk_ppn}, {43'd0, hit, p});
  endtask

  task automatic look_model(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                            input string req);
    logic [PPN_W:0] e;
    e = model_look(v, a);
    look(v, a, e[PPN_W], e[PPN_W-1:0], req);
  endtask

  task automatic cmd(input bit f, input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                     input bit g, input logic [ASID_W-1:0] a, input bit fa, input bit fl);
    fill_en = f; fill_vpn = v; fill_ppn = p; fill_global = g; cur_asid = a;
    flush_all = fa; flush_local = fl;
    @(posedge clk);
    model_apply(f, v, p, g, g ? '0 : a, fa, fl);
    @(negedge clk);
    fill_en = 0; flush_all = 0; flush_local = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [VPN_W-1:0] rv;
    logic [ASID_W-1:0] ra;
    logic [ASID_W-1:0] pool [4];
    pool[0] = 16'h0001; pool[1] = 16'h8001; pool[2] = 16'h0002; pool[3] = 16'h00ff;
    void'($urandom(32'h5eed));
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0;
    end
    m_rr = 0;
    rst_n = 0; fill_en = 0; fill_vpn = '0; fill_ppn = '0; fill_global = 0;
    flush_all = 0; flush_local = 0; cur_asid = '0; lk_vpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: empty after reset
    look(20'h00100, 16'h0001, 1'b0, '0, "R1");
    look(20'h00000, 16'h0000, 1'b0, '0, "R1");

    // R3 / R4: same page, tags differing in the top bit
    cmd(1, 20'h00100, 20'h0aaaa, 0, 16'h0001, 0, 0);
    look(20'h00100, 16'h0001, 1'b1, 20'h0aaaa, "R3");
    look(20'h00100, 16'h8001, 1'b0, '0, "R4");
    cmd(1, 20'h00100, 20'h0bbbb, 0, 16'h8001, 0, 0);
    look(20'h00100, 16'h0001, 1'b1, 20'h0aaaa, "R4");
    look(20'h00100, 16'h8001, 1'b1, 20'h0bbbb, "R4");

    // R2: shared slot visible under any tag
    cmd(1, 20'h00200, 20'h0cccc, 1, 16'h0001, 0, 0);
    look(20'h00200, 16'h1234, 1'b1, 20'h0cccc, "R2");
    look(20'h00201, 16'h0001, 1'b0, '0, "R2");

    // R6: local flush spares shared slot
    cmd(0, '0, '0, 0, 16'h0001, 0, 1);
    look(20'h00100, 16'h0001, 1'b0, '0, "R6");
    look(20'h00100, 16'h8001, 1'b0, '0, "R6");
    look(20'h00200, 16'h7777, 1'b1, 20'h0cccc, "R6");

    // R5: full flush
    cmd(0, '0, '0, 0, 16'h0001, 1, 0);
    look(20'h00200, 16'h7777, 1'b0, '0, "R5");

    // R9: flush wins over a same-cycle fill
    cmd(1, 20'h00300, 20'h01111, 0, 16'h0005, 1, 0);
    look(20'h00300, 16'h0005, 1'b0, '0, "R9");
    cmd(1, 20'h00300, 20'h01111, 0, 16'h0005, 0, 1);
    look(20'h00300, 16'h0005, 1'b0, '0, "R9");

    // R7: refill in place, then fill the rest: nothing lost
    cmd(1, 20'h00300, 20'h01111, 0, 16'h0005, 0, 0);
    cmd(1, 20'h00300, 20'h02222, 0, 16'h0005, 0, 0);
    look(20'h00300, 16'h0005, 1'b1, 20'h02222, "R7");
    for (int i = 1; i < ENTRIES; i++) cmd(1, VPN_W'(20'h00400 + i), PPN_W'(i), 0, 16'h0005, 0, 0);
    look(20'h00300, 16'h0005, 1'b1, 20'h02222, "R7");
    for (int i = 1; i < ENTRIES; i++) look(VPN_W'(20'h00400 + i), 16'h0005, 1'b1, PPN_W'(i), "R7");

    // R8: full buffer replaces slot 0, then slot 1
    cmd(1, 20'h00500, 20'h03333, 0, 16'h0005, 0, 0);
    look(20'h00300, 16'h0005, 1'b0, '0, "R8");
    look(20'h00500, 16'h0005, 1'b1, 20'h03333, "R8");
    look(20'h00401, 16'h0005, 1'b1, 20'h00001, "R8");
    cmd(1, 20'h00501, 20'h03334, 0, 16'h0005, 0, 0);
    look(20'h00401, 16'h0005, 1'b0, '0, "R8");
    look(20'h00402, 16'h0005, 1'b1, 20'h00002, "R8");

    // random phase against the model
    for (int it = 0; it < 4000; it++) begin
      int k;
      k = $urandom_range(0, 19);
      ra = pool[$urandom_range(0, 3)];
      if (k == 0) cmd(0, '0, '0, 0, ra, 1, 0);
      else if (k <= 2) cmd(0, '0, '0, 0, ra, 0, 1);
      else if (k <= 4) cmd(1, VPN_W'(20'h80000 + $urandom_range(0, 3)), PPN_W'($urandom), 1, ra, 0, 0);
      else if (k <= 12) cmd(1, VPN_W'($urandom_range(0, 11)), PPN_W'($urandom), 0, ra, 0, 0);
      else @(negedge clk);
      for (int j = 0; j < 2; j++) begin
        rv = ($urandom_range(0, 3) == 0) ? VPN_W'(20'h80000 + $urandom_range(0, 3))
                                         : VPN_W'($urandom_range(0, 11));
        look_model(rv, pool[$urandom_range(0, 3)], "R2 R8 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule